// File: doc/BRIEF.md
# Keystream core register front end

This block is the software-facing register window that sits in front of a 20/12/8-round keystream generator core. A host reaches it over a simple select/write-enable bus with an 8-bit word address and 32-bit data. It keeps the key, the nonce, the key-size selector, the round count and a 512-bit input block in local registers and presents them to the core as flat vectors. It also decodes one control word into two request levels for the core, start of a first block and continuation with the next block. Status and the 512-bit core result are read back one word at a time, highest-order word first.

A fixed identity (eight ASCII name characters and four ASCII version characters) can be read at the bottom of the map, so software can find the block before it uses it. Writes to read-only words do nothing and raise an error flag for the duration of the access. The core itself is not part of this block: it connects through the core-side ports, so the front end can be checked against a stub.

Top module: `keystream_regif`

## Requirements
- R1: A synchronous active-high reset clears every writable register: core_start, core_cont, core_wide_key, core_rounds, core_key, core_nonce and core_din all read 0 afterwards.
- R2: Address 0x00 reads ASCII "kstr" (32'h6b737472), 0x01 reads "eam1" (32'h65616d31) and 0x02 reads version "v1.0" (32'h76312e30); the first character sits in bits 31:24.
- R3: A write to 0x08 sets core_start from bit 0 and core_cont from bit 1 on that clock edge; both are levels held until the next write to 0x08, so writing 0 drops both. A read of 0x08 returns {cont, start} in bits 1:0.
- R4: A read of 0x09 returns core_ready in bit 0 and core_dout_valid in bit 1, all other bits 0.
- R5: Bit 0 of a write to 0x0a sets core_wide_key (0 = 128-bit key, 1 = 256-bit key); bits 4:0 of a write to 0x0b set core_rounds. Both read back with all other bits 0.
- R6: Key word k (0..7) lives at 0x10+k and drives core_key bits [255-32k -: 32], so word 0 is bits 255:224 and word 7 bits 31:0; each word reads back.
- R7: Nonce words live at 0x20 (core_nonce 63:32) and 0x21 (31:0); input word k (0..15) lives at 0x40+k and drives core_din bits [511-32k -: 32]; all read back.
- R8: A read of 0x80+k (k = 0..15) returns core_dout bits [511-32k -: 32]: 0x80 gives bits 511:480 and 0x8f bits 31:0.
- R9: State changes only on a clock edge where sel and wr_en are both high; with sel low nothing is written.
- R10: rdata is combinational from addr while sel is high and wr_en low, and 0 at all other times; unmapped addresses read 0.
- R11: A write to a read-only address (0x00-0x02, 0x09, 0x80-0x8f) changes no state, and err is high exactly while such a write is presented; err stays low for all other accesses, including writes to unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Bus select |
| wr_en | input | 1 | Write when high, read when low |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 when not reading |
| err | output | 1 | Write to a read-only word |
| core_start | output | 1 | First-block request level to the core |
| core_cont | output | 1 | Next-block request level to the core |
| core_key | output | 256 | Key, word 0 in the top bits |
| core_nonce | output | 64 | Nonce, word 0 in the top bits |
| core_wide_key | output | 1 | 1 selects a 256-bit key |
| core_rounds | output | 5 | Round count |
| core_din | output | 512 | Input block, word 0 in the top bits |
| core_ready | input | 1 | Core is idle and accepts a request |
| core_dout | input | 512 | Core result block |
| core_dout_valid | input | 1 | Core result is valid |

## Verification
The bench builds the block with its default sizes: eight key words, two nonce words, sixteen block words and a five-bit round field. Those values put every mapped word, the ends of each word bank and the first unmapped address after each bank within reach of the random address picker, so ordering of words inside the flat core vectors is checked at both ends. A stub replaces the core, driving ready, valid and a fresh random result block before each access, so status and result reads are checked against values the front end cannot have cached.

// File: rtl/kreg_pkg.sv
`timescale 1ns/1ps
package kreg_pkg;

    // word addresses that software decodes
    localparam int A_NAME0 = 'h00;
    localparam int A_NAME1 = 'h01;
    localparam int A_VER   = 'h02;
    localparam int A_CTRL  = 'h08;
    localparam int A_STAT  = 'h09;
    localparam int A_KLEN  = 'h0a;
    localparam int A_RND   = 'h0b;
    localparam int A_KEY   = 'h10;
    localparam int A_IV    = 'h20;
    localparam int A_DIN   = 'h40;
    localparam int A_DOUT  = 'h80;

    // bit positions inside the control and status words
    localparam int B_START = 0;
    localparam int B_CONT  = 1;
    localparam int B_READY = 0;
    localparam int B_VALID = 1;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_NAME0,
        RG_NAME1,
        RG_VER,
        RG_CTRL,
        RG_STAT,
        RG_KLEN,
        RG_RND,
        RG_KEY,
        RG_IV,
        RG_DIN,
        RG_DOUT
    } region_e;

    typedef struct packed {
        region_e    rg;
        logic [7:0] idx;
        logic       ro;
    } dec_t;

    function automatic logic is_read_only(region_e r);
        return r inside {RG_NAME0, RG_NAME1, RG_VER, RG_STAT, RG_DOUT};
    endfunction

    function automatic logic in_bank(int a, int base, int n);
        return (a >= base) && (a < base + n);
    endfunction

endpackage

// File: rtl/kreg_decode.sv
`timescale 1ns/1ps
module kreg_decode
    import kreg_pkg::*;
#(
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 2,
    parameter int BLK_WORDS = 16
) (
    input  logic [7:0] addr,
    output dec_t       dec
);

    always_comb begin
        int a;
        a   = int'(addr);
        dec = '{rg: RG_NONE, idx: 8'd0, ro: 1'b0};
        if (a == A_NAME0) begin
            dec.rg = RG_NAME0;
        end else if (a == A_NAME1) begin
            dec.rg = RG_NAME1;
        end else if (a == A_VER) begin
            dec.rg = RG_VER;
        end else if (a == A_CTRL) begin
            dec.rg = RG_CTRL;
        end else if (a == A_STAT) begin
            dec.rg = RG_STAT;
        end else if (a == A_KLEN) begin
            dec.rg = RG_KLEN;
        end else if (a == A_RND) begin
            dec.rg = RG_RND;
        end else if (in_bank(a, A_KEY, KEY_WORDS)) begin
            dec.rg  = RG_KEY;
            dec.idx = 8'(a - A_KEY);
        end else if (in_bank(a, A_IV, IV_WORDS)) begin
            dec.rg  = RG_IV;
            dec.idx = 8'(a - A_IV);
        end else if (in_bank(a, A_DIN, BLK_WORDS)) begin
            dec.rg  = RG_DIN;
            dec.idx = 8'(a - A_DIN);
        end else if (in_bank(a, A_DOUT, BLK_WORDS)) begin
            dec.rg  = RG_DOUT;
            dec.idx = 8'(a - A_DOUT);
        end
        dec.ro = is_read_only(dec.rg);
    end

endmodule

// File: rtl/kreg_ctrl.sv
`timescale 1ns/1ps
module kreg_ctrl
    import kreg_pkg::*;
#(
    parameter int ROUND_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  region_e            rg,
    input  logic [ROUND_W-1:0] wlow,
    output logic               start_q,
    output logic               cont_q,
    output logic               wide_q,
    output logic [ROUND_W-1:0] rounds_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= 1'b0;
            cont_q   <= 1'b0;
            wide_q   <= 1'b0;
            rounds_q <= '0;
        end else if (wr) begin
            case (rg)
                RG_CTRL: begin
                    start_q <= wlow[B_START];
                    cont_q  <= wlow[B_CONT];
                end
                RG_KLEN: wide_q   <= wlow[0];
                RG_RND:  rounds_q <= wlow;
                default: ;
            endcase
        end
    end

    // R3: request levels copy the written bits one edge later
    p_ctrl_follow_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && rg == RG_CTRL) |=> (start_q == $past(wlow[B_START]) && cont_q == $past(wlow[B_CONT])));

    // R9: without a write strobe the control fields hold
    p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ($stable(start_q) && $stable(cont_q) && $stable(wide_q) && $stable(rounds_q)));

    // R5: round field takes the low written bits
    p_rounds_load_r5: assert property (@(posedge clk) disable iff (rst)
        (wr && rg == RG_RND) |=> rounds_q == $past(wlow));

endmodule

// File: rtl/kreg_wordbank.sv
`timescale 1ns/1ps
module kreg_wordbank
    import kreg_pkg::*;
#(
    parameter int      WORD_W = 32,
    parameter int      N      = 8,
    parameter region_e MINE   = RG_KEY,
    localparam int     FLAT_W = N * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  region_e           rg,
    input  logic [7:0]        idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [FLAT_W-1:0] flat
);

    for (genvar i = 0; i < N; i++) begin : g_word
        logic [WORD_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr && rg == MINE && idx == 8'(i)) begin
                q <= wdata;
            end
        end

        // word 0 occupies the most significant slice
        assign flat[(N-1-i)*WORD_W +: WORD_W] = q;
    end

    // R9: a bank only moves on a write aimed at it
    p_bank_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr && rg == MINE) |=> $stable(flat));

endmodule

// File: rtl/kreg_rmux.sv
`timescale 1ns/1ps
module kreg_rmux
    import kreg_pkg::*;
#(
    parameter int                WORD_W    = 32,
    parameter int                KEY_WORDS = 8,
    parameter int                IV_WORDS  = 2,
    parameter int                BLK_WORDS = 16,
    parameter int                ROUND_W   = 5,
    parameter logic [WORD_W-1:0] ID_NAME0  = 32'h6b737472,
    parameter logic [WORD_W-1:0] ID_NAME1  = 32'h65616d31,
    parameter logic [WORD_W-1:0] ID_VER    = 32'h76312e30
) (
    input  logic                        rd,
    input  region_e                     rg,
    input  logic [7:0]                  idx,
    input  logic                        start_q,
    input  logic                        cont_q,
    input  logic                        ready,
    input  logic                        valid,
    input  logic                        wide_q,
    input  logic [ROUND_W-1:0]          rounds_q,
    input  logic [KEY_WORDS*WORD_W-1:0] key_flat,
    input  logic [IV_WORDS*WORD_W-1:0]  iv_flat,
    input  logic [BLK_WORDS*WORD_W-1:0] din_flat,
    input  logic [BLK_WORDS*WORD_W-1:0] dout_flat,
    output logic [WORD_W-1:0]           rdata
);

    always_comb begin
        int sl;
        sl    = 0;
        rdata = '0;
        if (rd) begin
            case (rg)
                RG_NAME0: rdata = ID_NAME0;
                RG_NAME1: rdata = ID_NAME1;
                RG_VER:   rdata = ID_VER;
                RG_CTRL: begin
                    rdata[B_START] = start_q;
                    rdata[B_CONT]  = cont_q;
                end
                RG_STAT: begin
                    rdata[B_READY] = ready;
                    rdata[B_VALID] = valid;
                end
                RG_KLEN: rdata[0] = wide_q;
                RG_RND:  rdata[ROUND_W-1:0] = rounds_q;
                RG_KEY: begin
                    sl    = KEY_WORDS - 1 - int'(idx);
                    rdata = key_flat[sl*WORD_W +: WORD_W];
                end
                RG_IV: begin
                    sl    = IV_WORDS - 1 - int'(idx);
                    rdata = iv_flat[sl*WORD_W +: WORD_W];
                end
                RG_DIN: begin
                    sl    = BLK_WORDS - 1 - int'(idx);
                    rdata = din_flat[sl*WORD_W +: WORD_W];
                end
                RG_DOUT: begin
                    sl    = BLK_WORDS - 1 - int'(idx);
                    rdata = dout_flat[sl*WORD_W +: WORD_W];
                end
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/keystream_regif.sv
`timescale 1ns/1ps
module keystream_regif
    import kreg_pkg::*;
#(
    parameter int  WORD_W    = 32,
    parameter int  KEY_WORDS = 8,
    parameter int  IV_WORDS  = 2,
    parameter int  BLK_WORDS = 16,
    parameter int  ROUND_W   = 5,
    localparam int KEY_W     = KEY_WORDS * WORD_W,
    localparam int IV_W      = IV_WORDS * WORD_W,
    localparam int BLK_W     = BLK_WORDS * WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               wr_en,
    input  logic [7:0]         addr,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rdata,
    output logic               err,
    output logic               core_start,
    output logic               core_cont,
    output logic [KEY_W-1:0]   core_key,
    output logic [IV_W-1:0]    core_nonce,
    output logic               core_wide_key,
    output logic [ROUND_W-1:0] core_rounds,
    output logic [BLK_W-1:0]   core_din,
    input  logic               core_ready,
    input  logic [BLK_W-1:0]   core_dout,
    input  logic               core_dout_valid
);

    dec_t dec;
    logic wr;
    logic rd;

    assign wr  = sel & wr_en;
    assign rd  = sel & ~wr_en;
    assign err = wr & dec.ro;

    kreg_decode #(
        .KEY_WORDS(KEY_WORDS),
        .IV_WORDS (IV_WORDS),
        .BLK_WORDS(BLK_WORDS)
    ) u_decode (
        .addr(addr),
        .dec (dec)
    );

    kreg_ctrl #(
        .ROUND_W(ROUND_W)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rg      (dec.rg),
        .wlow    (wdata[ROUND_W-1:0]),
        .start_q (core_start),
        .cont_q  (core_cont),
        .wide_q  (core_wide_key),
        .rounds_q(core_rounds)
    );

    kreg_wordbank #(.WORD_W(WORD_W), .N(KEY_WORDS), .MINE(RG_KEY)) u_key_bank (
        .clk(clk), .rst(rst), .wr(wr), .rg(dec.rg), .idx(dec.idx),
        .wdata(wdata), .flat(core_key)
    );

    kreg_wordbank #(.WORD_W(WORD_W), .N(IV_WORDS), .MINE(RG_IV)) u_iv_bank (
        .clk(clk), .rst(rst), .wr(wr), .rg(dec.rg), .idx(dec.idx),
        .wdata(wdata), .flat(core_nonce)
    );

    kreg_wordbank #(.WORD_W(WORD_W), .N(BLK_WORDS), .MINE(RG_DIN)) u_din_bank (
        .clk(clk), .rst(rst), .wr(wr), .rg(dec.rg), .idx(dec.idx),
        .wdata(wdata), .flat(core_din)
    );

    kreg_rmux #(
        .WORD_W   (WORD_W),
        .KEY_WORDS(KEY_WORDS),
        .IV_WORDS (IV_WORDS),
        .BLK_WORDS(BLK_WORDS),
        .ROUND_W  (ROUND_W)
    ) u_rmux (
        .rd       (rd),
        .rg       (dec.rg),
        .idx      (dec.idx),
        .start_q  (core_start),
        .cont_q   (core_cont),
        .ready    (core_ready),
        .valid    (core_dout_valid),
        .wide_q   (core_wide_key),
        .rounds_q (core_rounds),
        .key_flat (core_key),
        .iv_flat  (core_nonce),
        .din_flat (core_din),
        .dout_flat(core_dout),
        .rdata    (rdata)
    );

    // R11: a flagged write leaves every core-facing register untouched
    p_err_no_effect_r11: assert property (@(posedge clk) disable iff (rst)
        err |=> ($stable(core_key) && $stable(core_nonce) && $stable(core_din) &&
                 $stable(core_start) && $stable(core_cont) &&
                 $stable(core_wide_key) && $stable(core_rounds)));

    // R11: the flag never appears outside a write
    p_err_on_write_r11: assert property (@(posedge clk) disable iff (rst)
        err |-> (sel && wr_en));

    // R10: the read bus is quiet unless a read is presented
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !(sel && !wr_en) |-> rdata == '0);

    // R4: status word mirrors the core flags
    p_status_r4: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr_en && addr == 8'(A_STAT)) |->
            (rdata[B_READY] == core_ready && rdata[B_VALID] == core_dout_valid));

    // R8: first result word is the top slice of the core result
    p_dout_top_r8: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr_en && addr == 8'(A_DOUT)) |-> rdata == core_dout[BLK_W-1 -: WORD_W]);

endmodule

// File: tb/keystream_regif_bench.sv
`timescale 1ns/1ps
module keystream_regif_bench;

    localparam int KW = 8;
    localparam int IW = 2;
    localparam int BW = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = 8'h0;
    logic [31:0]  wdata = 32'h0;
    logic [31:0]  rdata;
    logic         err;
    logic         core_start, core_cont, core_wide_key;
    logic [255:0] core_key;
    logic [63:0]  core_nonce;
    logic [4:0]   core_rounds;
    logic [511:0] core_din;
    logic         stub_ready = 1'b0;
    logic [511:0] stub_dout = '0;
    logic         stub_valid = 1'b0;

    always #4 clk = ~clk;

    keystream_regif u_keystream_regif (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err(err),
        .core_start(core_start), .core_cont(core_cont), .core_key(core_key),
        .core_nonce(core_nonce), .core_wide_key(core_wide_key),
        .core_rounds(core_rounds), .core_din(core_din),
        .core_ready(stub_ready), .core_dout(stub_dout),
        .core_dout_valid(stub_valid)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] m_key [KW];
    logic [31:0] m_iv  [IW];
    logic [31:0] m_din [BW];
    logic        m_start, m_cont, m_wide;
    logic [4:0]  m_rnd;

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic mdl_reset();
        for (int i = 0; i < KW; i++) m_key[i] = '0;
        for (int i = 0; i < IW; i++) m_iv[i] = '0;
        for (int i = 0; i < BW; i++) m_din[i] = '0;
        m_start = 0; m_cont = 0; m_wide = 0; m_rnd = '0;
    endtask

    function automatic logic [255:0] pack_key();
        logic [255:0] r;
        for (int i = 0; i < KW; i++) r[(KW-1-i)*32 +: 32] = m_key[i];
        return r;
    endfunction

    function automatic logic [63:0] pack_iv();
        return {m_iv[0], m_iv[1]};
    endfunction

    function automatic logic [511:0] pack_din();
        logic [511:0] r;
        for (int i = 0; i < BW; i++) r[(BW-1-i)*32 +: 32] = m_din[i];
        return r;
    endfunction

    function automatic logic is_ro(logic [7:0] a);
        int x = int'(a);
        return (x <= 2) || (x == 9) || (x >= 128 && x < 128 + BW);
    endfunction

    function automatic string tag_of(logic [7:0] a);
        int x = int'(a);
        if (x <= 2) return "R2";
        if (x == 8) return "R3";
        if (x == 9) return "R4";
        if (x == 10 || x == 11) return "R5";
        if (x >= 16 && x < 16 + KW) return "R6";
        if ((x >= 32 && x < 32 + IW) || (x >= 64 && x < 64 + BW)) return "R7";
        if (x >= 128 && x < 128 + BW) return "R8";
        return "R10";
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        int x = int'(a);
        if (x == 0) return 32'h6b737472;
        if (x == 1) return 32'h65616d31;
        if (x == 2) return 32'h76312e30;
        if (x == 8) return {30'b0, m_cont, m_start};
        if (x == 9) return {30'b0, stub_valid, stub_ready};
        if (x == 10) return {31'b0, m_wide};
        if (x == 11) return {27'b0, m_rnd};
        if (x >= 16 && x < 16 + KW) return m_key[x-16];
        if (x >= 32 && x < 32 + IW) return m_iv[x-32];
        if (x >= 64 && x < 64 + BW) return m_din[x-64];
        if (x >= 128 && x < 128 + BW) return stub_dout[(BW-1-(x-128))*32 +: 32];
        return 32'h0;
    endfunction

    task automatic mdl_write(input logic [7:0] a, input logic [31:0] d);
        int x = int'(a);
        if (x == 8) begin m_start = d[0]; m_cont = d[1]; end
        else if (x == 10) m_wide = d[0];
        else if (x == 11) m_rnd = d[4:0];
        else if (x >= 16 && x < 16 + KW) m_key[x-16] = d;
        else if (x >= 32 && x < 32 + IW) m_iv[x-32] = d;
        else if (x >= 64 && x < 64 + BW) m_din[x-64] = d;
    endtask

    task automatic check_core(input string tag);
        chk(tag, core_key, pack_key());
        chk(tag, core_nonce, pack_iv());
        chk(tag, core_din, pack_din());
        chk(tag, {core_start, core_cont, core_wide_key, core_rounds},
                 {m_start, m_cont, m_wide, m_rnd});
    endtask

    // one bus access: present at a falling edge, check the combinational
    // outputs 1 ns later, check registered state at the following falling edge
    task automatic bus(input logic s, input logic w, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] er;
        string t;
        @(negedge clk);
        sel = s; wr_en = w; addr = a; wdata = d;
        #1;
        er = (s && !w) ? exp_read(a) : 32'h0;
        t  = (s && !w) ? tag_of(a) : "R10";
        chk(t, rdata, er);
        chk("R11", err, s && w && is_ro(a));
        @(negedge clk);
        if (s && w) mdl_write(a, d);
        sel = 0; wr_en = 0;
        if (s && w) t = is_ro(a) ? "R11" : tag_of(a);
        else t = "R9";
        check_core(t);
    endtask

    task automatic new_stub();
        stub_ready = 1'($urandom);
        stub_valid = 1'($urandom);
        for (int i = 0; i < BW; i++) stub_dout[i*32 +: 32] = $urandom;
    endtask

    function automatic logic [7:0] pick_addr();
        case ($urandom % 8)
            0: return 8'($urandom % 3);
            1: return 8'(8 + $urandom % 4);
            2: return 8'(16 + $urandom % (KW + 1));
            3: return 8'(32 + $urandom % (IW + 1));
            4: return 8'(64 + $urandom % (BW + 1));
            5: return 8'(128 + $urandom % (BW + 1));
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0017));
        mdl_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state at the ports
        check_core("R1");
        chk("R1", err, 1'b0);
        chk("R10", rdata, 32'h0);

        // R2: identity words
        bus(1, 0, 8'h00, 0);
        bus(1, 0, 8'h01, 0);
        bus(1, 0, 8'h02, 0);
        chk("R2", exp_read(8'h00), 32'h6b737472);

        // R6: key word ordering at both ends
        for (int i = 0; i < KW; i++) bus(1, 1, 8'(16 + i), 32'h1000_0000 + i);
        chk("R6", core_key[255:224], 32'h1000_0000);
        chk("R6", core_key[31:0], 32'h1000_0007);
        bus(1, 0, 8'h17, 0);

        // R7: nonce and input block ordering
        bus(1, 1, 8'h20, 32'haaaa_0000);
        bus(1, 1, 8'h21, 32'h0000_bbbb);
        chk("R7", core_nonce, 64'haaaa_0000_0000_bbbb);
        bus(1, 1, 8'h40, 32'hdead_beef);
        bus(1, 1, 8'h4f, 32'hcafe_f00d);
        chk("R7", core_din[511:480], 32'hdead_beef);
        chk("R7", core_din[31:0], 32'hcafe_f00d);

        // R3: request bits as levels
        bus(1, 1, 8'h08, 32'h1);
        chk("R3", {core_start, core_cont}, 2'b10);
        bus(1, 1, 8'h08, 32'h2);
        chk("R3", {core_start, core_cont}, 2'b01);
        bus(1, 1, 8'h08, 32'hffff_ffff);
        bus(1, 0, 8'h08, 0);
        bus(1, 1, 8'h08, 32'h0);
        chk("R3", {core_start, core_cont}, 2'b00);

        // R5: key length and round fields
        bus(1, 1, 8'h0a, 32'hffff_fffe);
        chk("R5", core_wide_key, 1'b0);
        bus(1, 1, 8'h0a, 32'h1);
        chk("R5", core_wide_key, 1'b1);
        bus(1, 1, 8'h0b, 32'hffff_ffec);
        chk("R5", core_rounds, 5'h0c);
        bus(1, 0, 8'h0b, 0);

        // R4 / R8: status and result words from the stub
        stub_ready = 1; stub_valid = 0;
        for (int i = 0; i < BW; i++) stub_dout[i*32 +: 32] = 32'h5000_0000 + i;
        bus(1, 0, 8'h09, 0);
        bus(1, 0, 8'h80, 0);
        bus(1, 0, 8'h8f, 0);
        chk("R8", exp_read(8'h80), 32'h5000_000f);

        // R11: write to read-only words
        bus(1, 1, 8'h09, 32'hffff_ffff);
        bus(1, 1, 8'h81, 32'h1234_5678);
        bus(1, 1, 8'h00, 32'h0);
        bus(1, 0, 8'h09, 0);

        // R9: select low blocks a write
        bus(0, 1, 8'h10, 32'h0bad_0bad);
        bus(1, 0, 8'h10, 0);

        // R10: unmapped read and idle bus
        bus(1, 0, 8'h30, 0);
        bus(1, 0, 8'hff, 0);
        bus(0, 0, 8'h00, 0);

        // random mix against the bench model
        for (int n = 0; n < 1500; n++) begin
            logic [7:0] a;
            new_stub();
            a = pick_addr();
            bus(($urandom % 8) != 0, 1'($urandom), a, $urandom);
        end

        // R1: reset in the middle of traffic
        bus(1, 1, 8'h08, 32'h3);
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        mdl_reset();
        #1;
        check_core("R1");
        bus(1, 0, 8'h08, 0);
        bus(1, 0, 8'h13, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule